// File: doc/BRIEF.md
# Programmable Burst Column Sequencer

This block produces the column addresses for one burst access to a synchronous DRAM bank whose rows hold 256 columns. When a read or write command arrives with a start column, the sequencer puts that column out in the next cycle. It then steps through one column per clock, in an order and for a count chosen by a small mode register. That register holds the burst length, linear or interleaved order, the read latency, and a switch that makes every write a single beat. It is loaded through a strobe and rejects any write that contains an illegal code.

The column stream is a pure source: `col_valid` qualifies each beat and there is no ready input, because the array cannot be stalled, so downstream logic must accept every beat in the cycle it appears. A burst ends when its last beat is emitted, when a stop request arrives, or when a new command replaces it. A command flagged for auto precharge raises a one-cycle precharge request after a burst that completes on its own. For reads, a data-valid strobe trails each beat by the latched read latency.

Top module: `burst_col_seq`

## Requirements
- R1: A command sampled on a clock edge makes `col_valid` high in the following cycle with `col_addr` equal to the command's start column, and one new beat is emitted each cycle after that.
- R2: Mode field bits 2:0 pick the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. `col_last` is high only on the final beat, and `col_valid` falls after it unless a new command arrived.
- R3: With mode bit 3 clear (linear order), the column steps upward inside the block of burst-length columns that is aligned to that length and contains the start column, wrapping to the bottom of that block.
- R4: With mode bit 3 set (interleaved order), beat k carries the aligned block base plus (start offset XOR k).
- R5: Length code 111 selects a full page: the column steps upward from 255 to 0 and keeps running, `col_last` stays low, and only a stop or a new command ends it.
- R6: With mode bit 9 set, a write command is one beat long while a read keeps the programmed length. `col_write` is high on every beat of a write burst.
- R7: Mode bits 6:4 hold the read latency (1, 2 or 3), latched when the command is accepted. `rd_data_valid` is high exactly that many cycles after each read beat, and write beats never raise it.
- R8: `burst_stop` sampled during a burst drops `col_valid` in the next cycle. A command in the same cycle takes priority over the stop.
- R9: A command that arrives during a burst abandons the old burst, and the new start column appears in the next cycle.
- R10: When the command carried `cmd_auto_pre`, `pre_req` pulses for one cycle right after a final beat. It is not raised when the burst ended through a stop or was replaced by a command in its last cycle.
- R11: A mode write with an illegal length code (100, 101, 110), a read latency of 0 or above 3, or a full page combined with interleaved order leaves the whole register unchanged.
- R12: After reset, `col_valid`, `col_last`, `rd_data_valid` and `pre_req` are low, and the mode register holds length 1, linear order, read latency 2 and single-write off. A mode write in the same cycle as a command affects only later commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_we | input | 1 | Mode register load strobe |
| mrs_data | input | 10 | Mode value to load |
| cmd_valid | input | 1 | Read or write command present this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_auto_pre | input | 1 | Request precharge at the natural end of the burst |
| cmd_col | input | COL_W | Start column of the burst |
| burst_stop | input | 1 | Terminate the running burst |
| col_valid | output | 1 | A column beat is present |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one |
| col_write | output | 1 | Current beat belongs to a write burst |
| rd_data_valid | output | 1 | Read data of an earlier beat is due this cycle |
| pre_req | output | 1 | One-cycle row precharge request |

## Verification
On every cycle, the assertions check the timing relations that need no knowledge of the mode. A command is always followed by its start column. A beat that is neither last nor stopped is followed by another. A stop without a command empties the stream. `col_last` only marks live beats. A precharge pulse lasts one cycle and follows a final beat. The address order within linear, interleaved and full-page bursts, the single-write shortening, the latency of the read strobe, and the rejection of illegal mode codes depend on the latched configuration. These are shown only by the bench's scenarios, where a behavioural model tracks the expected column, flags and strobes cycle by cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int MODE_W = 10;
  localparam int CL_W   = 2;

  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } blen_e;

  typedef struct packed {
    blen_e            len;
    logic             interleave;
    logic [CL_W-1:0]  cas_lat;
    logic             single_wr;
  } mode_cfg_t;

  localparam mode_cfg_t MODE_RESET = '{len: BL_1, interleave: 1'b0,
                                       cas_lat: 2'd2, single_wr: 1'b0};

  function automatic logic len_code_ok(input logic [2:0] code);
    return (code == BL_1) || (code == BL_2) || (code == BL_4) ||
           (code == BL_8) || (code == BL_PAGE);
  endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output mode_cfg_t         cfg
);

  logic [2:0]      f_len;
  logic            f_itl;
  logic [2:0]      f_cl;
  logic            f_sw;
  logic            legal;
  mode_cfg_t       decoded;

  always_comb begin
    f_len = wr_data[2:0];
    f_itl = wr_data[3];
    f_cl  = wr_data[6:4];
    f_sw  = wr_data[9];
    legal = len_code_ok(f_len) &&
            (f_cl >= 3'd1) && (f_cl <= 3'd3) &&
            !((f_len == BL_PAGE) && f_itl);
    decoded.len        = blen_e'(f_len);
    decoded.interleave = f_itl;
    decoded.cas_lat    = f_cl[CL_W-1:0];
    decoded.single_wr  = f_sw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= MODE_RESET;
    end else if (wr_en && legal) begin
      cfg <= decoded;
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat_idx,
  input  blen_e            len,
  input  logic             interleave,
  output logic [COL_W-1:0] wrap_mask,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] stepped;

  always_comb begin
    unique case (len)
      BL_1:    wrap_mask = '0;
      BL_2:    wrap_mask = COL_W'(1);
      BL_4:    wrap_mask = COL_W'(3);
      BL_8:    wrap_mask = COL_W'(7);
      default: wrap_mask = '1;
    endcase
    stepped = interleave ? (start_col ^ beat_idx) : (start_col + beat_idx);
    col = (start_col & ~wrap_mask) | (stepped & wrap_mask);
  end

endmodule

// File: rtl/cas_delay_line.sv
module cas_delay_line
  import burst_seq_pkg::*;
#(
  parameter int MAX_CL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_beat,
  input  logic [CL_W-1:0] lat,
  output logic            data_valid
);

  logic [MAX_CL-1:0] stage;
  logic [MAX_CL-1:0] insert;
  logic [MAX_CL-1:0] shifted;

  generate
    for (genvar i = 0; i < MAX_CL; i++) begin : g_ins
      assign insert[i] = rd_beat && (int'(lat) == i + 1);
    end
    if (MAX_CL > 1) begin : g_shift
      assign shifted = {1'b0, stage[MAX_CL-1:1]};
    end else begin : g_noshift
      assign shifted = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else        stage <= shifted | insert;
  end

  assign data_valid = stage[0];

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_we,
  input  logic [9:0]       mrs_data,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic             cmd_auto_pre,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             burst_stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             col_write,
  output logic             rd_data_valid,
  output logic             pre_req
);

  mode_cfg_t        cfg;

  logic             b_active;
  logic [COL_W-1:0] b_start;
  logic [COL_W-1:0] b_idx;
  blen_e            b_len;
  logic             b_itl;
  logic             b_wr;
  logic             b_ap;
  logic [CL_W-1:0]  b_cl;

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] gen_col;
  logic             at_end;
  logic             natural_end;
  blen_e            load_len;

  burst_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mrs_we),
    .wr_data (mrs_data),
    .cfg     (cfg)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .start_col  (b_start),
    .beat_idx   (b_idx),
    .len        (b_len),
    .interleave (b_itl),
    .wrap_mask  (wrap_mask),
    .col        (gen_col)
  );

  cas_delay_line #(.MAX_CL(MAX_CL)) u_cas (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_beat    (b_active && !b_wr),
    .lat        (b_cl),
    .data_valid (rd_data_valid)
  );

  always_comb begin
    at_end      = b_active && (b_len != BL_PAGE) && (b_idx == wrap_mask);
    natural_end = at_end && !cmd_valid && !burst_stop;
    load_len    = (cmd_write && cfg.single_wr) ? BL_1 : cfg.len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_active <= 1'b0;
      b_start  <= '0;
      b_idx    <= '0;
      b_len    <= BL_1;
      b_itl    <= 1'b0;
      b_wr     <= 1'b0;
      b_ap     <= 1'b0;
      b_cl     <= MODE_RESET.cas_lat;
      pre_req  <= 1'b0;
    end else begin
      pre_req <= natural_end && b_ap;
      if (cmd_valid) begin
        b_active <= 1'b1;
        b_start  <= cmd_col;
        b_idx    <= '0;
        b_len    <= load_len;
        b_itl    <= cfg.interleave;
        b_wr     <= cmd_write;
        b_ap     <= cmd_auto_pre;
        b_cl     <= cfg.cas_lat;
      end else if (b_active && (burst_stop || at_end)) begin
        b_active <= 1'b0;
      end else if (b_active) begin
        b_idx <= b_idx + COL_W'(1);
      end
    end
  end

  assign col_valid = b_active;
  assign col_addr  = gen_col;
  assign col_last  = at_end;
  assign col_write = b_active && b_wr;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [COL_W-1:0] cmd_col,
  input logic             burst_stop,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last,
  input logic             pre_req
);

  assert_cmd_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

  assert_beats_continue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !cmd_valid && !burst_stop) |=> col_valid);

  assert_last_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  assert_last_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !cmd_valid) |=> !col_valid);

  assert_stop_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_stop && !cmd_valid) |=> !col_valid);

  assert_pre_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> ($past(col_last) && !$past(cmd_valid) && !$past(burst_stop)));

  assert_pre_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |=> !pre_req);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_col    (cmd_col),
  .burst_stop (burst_stop),
  .col_valid  (col_valid),
  .col_addr   (col_addr),
  .col_last   (col_last),
  .pre_req    (pre_req)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mrs_we = 1'b0;
  logic [9:0] mrs_data = '0;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic       cmd_auto_pre = 1'b0;
  logic [7:0] cmd_col = '0;
  logic       burst_stop = 1'b0;
  logic       col_valid, col_last, col_write, rd_data_valid, pre_req;
  logic [7:0] col_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R12";

  always #10 clk = ~clk;

  burst_col_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mrs_we(mrs_we), .mrs_data(mrs_data),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_auto_pre(cmd_auto_pre),
    .cmd_col(cmd_col), .burst_stop(burst_stop), .col_valid(col_valid),
    .col_addr(col_addr), .col_last(col_last), .col_write(col_write),
    .rd_data_valid(rd_data_valid), .pre_req(pre_req)
  );

  // behavioural reference state
  int m_active, m_start, m_idx, m_len, m_itl, m_wr, m_ap, m_cl;
  int mo_len = 1, mo_itl = 0, mo_cl = 2, mo_sw = 0;
  int exp_pre = 0;
  int sched[4];

  function automatic int code_to_len(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic int ref_addr();
    int base, off;
    if (m_len == 0) return (m_start + m_idx) % 256;
    off  = m_start % m_len;
    base = m_start - off;
    if (m_itl != 0) return base + (off ^ m_idx);
    return base + ((off + m_idx) % m_len);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_active = 0; m_idx = 0; m_start = 0; m_len = 1; m_wr = 0; m_ap = 0;
      m_itl = 0; m_cl = 2; exp_pre = 0;
      mo_len = 1; mo_itl = 0; mo_cl = 2; mo_sw = 0;
      for (int i = 0; i < 4; i++) sched[i] = 0;
    end else begin
      int last_now, beat_rd, nl, ncl;
      last_now = (m_active != 0 && m_len != 0 && m_idx == m_len - 1) ? 1 : 0;
      beat_rd  = (m_active != 0 && m_wr == 0) ? 1 : 0;
      exp_pre  = (last_now != 0 && m_ap != 0 && !cmd_valid && !burst_stop) ? 1 : 0;
      for (int i = 0; i < 3; i++) sched[i] = sched[i+1];
      sched[3] = 0;
      if (beat_rd != 0) sched[m_cl-1] = 1;
      if (cmd_valid) begin
        m_active = 1; m_start = int'(cmd_col); m_idx = 0;
        m_len = (cmd_write && mo_sw != 0) ? 1 : mo_len;
        m_itl = mo_itl; m_cl = mo_cl; m_wr = int'(cmd_write); m_ap = int'(cmd_auto_pre);
      end else if (m_active != 0 && (burst_stop || last_now != 0)) begin
        m_active = 0;
      end else if (m_active != 0) begin
        m_idx = (m_idx + 1) % 256;
      end
      if (mrs_we) begin
        nl  = code_to_len(int'(mrs_data[2:0]));
        ncl = int'(mrs_data[6:4]);
        if (nl >= 0 && ncl >= 1 && ncl <= 3 && !(nl == 0 && mrs_data[3])) begin
          mo_len = nl; mo_itl = int'(mrs_data[3]); mo_cl = ncl; mo_sw = int'(mrs_data[9]);
        end
      end
    end
  end

  task automatic report(input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", cur_req, what, act, exp, cycles);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(col_valid) != m_active) report("col_valid", int'(col_valid), m_active);
      else if (m_active != 0) begin
        if (int'(col_addr) != ref_addr()) report("col_addr", int'(col_addr), ref_addr());
        if (int'(col_last) != ((m_len != 0 && m_idx == m_len - 1) ? 1 : 0))
          report("col_last", int'(col_last), (m_len != 0 && m_idx == m_len - 1) ? 1 : 0);
        if (int'(col_write) != m_wr) report("col_write", int'(col_write), m_wr);
      end else if (col_last || col_write) begin
        report("idle flags", int'(col_last) + int'(col_write), 0);
      end
      if (int'(rd_data_valid) != sched[0]) report("rd_data_valid", int'(rd_data_valid), sched[0]);
      if (int'(pre_req) != exp_pre) report("pre_req", int'(pre_req), exp_pre);
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mrs(input logic [9:0] v);
    mrs_we = 1'b1; mrs_data = v; tick(); mrs_we = 1'b0;
  endtask

  task automatic issue(input logic [7:0] c, input logic w, input logic ap);
    cmd_valid = 1'b1; cmd_col = c; cmd_write = w; cmd_auto_pre = ap;
    tick();
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_auto_pre = 1'b0;
  endtask

  task automatic stop_now();
    burst_stop = 1'b1; tick(); burst_stop = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R12: reset state seen at the ports
    checks++;
    if (col_valid || col_last || rd_data_valid || pre_req) begin
      fails++;
      $display("FAIL R12 reset outputs: actual %0d expected 0",
               int'(col_valid) + int'(col_last) + int'(rd_data_valid) + int'(pre_req));
    end
    cur_req = "R12"; issue(8'd5, 1'b0, 1'b0); tick(4);          // default BL1, CL2
    cur_req = "R3";  mrs(10'h012); issue(8'd6, 1'b0, 1'b0); tick(6);   // BL4 linear CL1
    cur_req = "R4";  mrs(10'h03B); issue(8'd13, 1'b0, 1'b0); tick(12); // BL8 interleaved CL3
    cur_req = "R2";  mrs(10'h021); issue(8'd9, 1'b1, 1'b1); tick(4);   // BL2 write, R10 precharge
    cur_req = "R10"; mrs(10'h012); issue(8'd3, 1'b0, 1'b1); tick(6);
    cur_req = "R5";  mrs(10'h027); issue(8'd253, 1'b0, 1'b1); tick(6);
    cur_req = "R8";  stop_now(); tick(4);
    cur_req = "R6";  mrs(10'h213); issue(8'd20, 1'b1, 1'b1); tick(3);
    issue(8'd20, 1'b0, 1'b0); tick(10);
    cur_req = "R11"; mrs(10'h00F); mrs(10'h004); mrs(10'h073); mrs(10'h000);
    issue(8'd33, 1'b0, 1'b0); tick(12);
    cur_req = "R9";  mrs(10'h033); issue(8'd40, 1'b0, 1'b1); tick(2);
    issue(8'd50, 1'b1, 1'b1); tick(10);
    cur_req = "R10"; issue(8'd60, 1'b0, 1'b1); tick(6); stop_now(); tick(4);
    issue(8'd16, 1'b0, 1'b1); tick(6); issue(8'd70, 1'b0, 1'b0); tick(10);
    cur_req = "R8";  issue(8'd90, 1'b0, 1'b0); burst_stop = 1'b1; issue(8'd91, 1'b0, 1'b0);
    burst_stop = 1'b0; tick(10);
    cur_req = "R7";  mrs(10'h01A); issue(8'd100, 1'b0, 1'b0); mrs(10'h033); tick(2);
    issue(8'd120, 1'b1, 1'b0); tick(10);
    cur_req = "R1";
    for (int i = 0; i < 600; i++) begin
      logic [9:0] modes[8] = '{10'h010, 10'h021, 10'h032, 10'h01B, 10'h237,
                                10'h03A, 10'h00F, 10'h004};
      cmd_valid    = ($urandom_range(0, 5) == 0);
      cmd_write    = $urandom_range(0, 1) == 1;
      cmd_auto_pre = $urandom_range(0, 1) == 1;
      cmd_col      = 8'($urandom_range(0, 255));
      burst_stop   = ($urandom_range(0, 9) == 0);
      mrs_we       = ($urandom_range(0, 15) == 0);
      mrs_data     = modes[$urandom_range(0, 7)];
      tick();
    end
    cmd_valid = 1'b0; burst_stop = 1'b1; mrs_we = 1'b0; tick(); burst_stop = 1'b0;
    tick(6);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule